// File: doc/BRIEF.md
# Double-Buffered Scaler Coefficient Loader

This block fills a polyphase scaler's coefficient RAM from an external coefficient table. A start command names one of six filter slots, gives a tap count and a table identifier. The block then walks phases 0 to 32 of a 64-phase filter, since the remaining phases follow by symmetry. Within each phase it walks tap pairs, one RAM write per clock. Each write word packs an even-tap and an odd-tap coefficient, and each half has its own write enable. The table is read combinationally through two address ports, one for the even coefficient and one for the odd.

Writes always go to the shadow bank, which is the bank the scaler is not using. After a complete load a swap is marked pending. The active-bank select flips at the next frame-boundary strobe that arrives while the loader is idle, so the bank in use never changes within a frame or under an open load. A table identifier that matches the one last loaded into the same slot causes no reload. A tap count below two also causes no reload. When the tap counts of both the requested component and its partner component are exactly two, the direction switches to fixed 2-tap coefficients and no RAM load is done.

Top module: `scl_coef_loader`

## Requirements
- R1: After reset there is no RAM write, no done pulse and no busy indication, the active bank is 0, and all hard-code and sharpen flags are low.
- R2: An accepted load writes phases 0 to 32 in increasing order. Within each phase it writes pairs 0 to (taps+1)/2-1, pair first. There is one write per cycle, starting the cycle after the start command and with busy high. The type field carries the requested code: 0 luma vertical, 1 luma horizontal, 2 chroma vertical, 3 chroma horizontal, 4 alpha vertical, 5 alpha horizontal. Bit 0 set means horizontal.
- R3: For pair p of phase ph, the even half equals table[ph*taps+2p]. The odd half equals table[ph*taps+2p+1], or zero when 2p+1 is not less than taps. Each half is the table word shifted left by two, so bits 1:0 are zero. Both half enables are high with every write.
- R4: Every write targets the bank that is not active.
- R5: done_o pulses one cycle after the last write of a load, and a swap becomes pending. The active bank inverts at the first frame_i cycle in which the loader is idle with a swap pending. It never changes while busy.
- R6: A start whose identifier equals the one last fully loaded into the same filter slot performs no write and no swap, and pulses done_o in the next cycle.
- R7: A start with a tap count of 0 or 1 performs no write and pulses done_o in the next cycle.
- R8: On every accepted start, the hard-code flag of that filter's direction becomes (taps == 2 and partner taps == 2). Its sharpen flag becomes that value ANDed with a non-zero sharpness level. When the hard-code flag is set, no write occurs and done_o pulses in the next cycle.
- R9: A start is ignored while busy, with a type code above 5, or with more than 8 taps: no write, no done pulse, and no flag change.
- R10: A frame_i strobe with no pending swap leaves the active bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load request |
| filt_type_i | input | 3 | Filter slot code |
| taps_i | input | TAP_W | Tap count of the requested filter |
| partner_taps_i | input | TAP_W | Tap count of the other component in the same direction |
| sharp_lvl_i | input | SHARP_W | Sharpness level for 2-tap mode |
| tbl_id_i | input | ID_W | Identifier of the requested table |
| frame_i | input | 1 | Frame-boundary strobe |
| tbl_even_addr_o | output | TADDR_W | Table address of the even coefficient |
| tbl_odd_addr_o | output | TADDR_W | Table address of the odd coefficient |
| tbl_even_i | input | TBL_W | Table word at the even address |
| tbl_odd_i | input | TBL_W | Table word at the odd address |
| ram_we_o | output | 1 | RAM write strobe |
| ram_bank_o | output | 1 | Bank written |
| ram_type_o | output | 3 | Filter slot written |
| ram_phase_o | output | PH_W | Phase written |
| ram_pair_o | output | PAIR_W | Tap pair written |
| ram_even_o | output | COEF_W | Even coefficient |
| ram_even_en_o | output | 1 | Even half enable |
| ram_odd_o | output | COEF_W | Odd coefficient |
| ram_odd_en_o | output | 1 | Odd half enable |
| done_o | output | 1 | Command completion pulse |
| busy_o | output | 1 | Load in progress |
| active_bank_o | output | 1 | Bank in use by the scaler |
| hc_h_o | output | 1 | Horizontal 2-tap hard-code enable |
| hc_v_o | output | 1 | Vertical 2-tap hard-code enable |
| sharp_h_o | output | 1 | Horizontal 2-tap sharpen enable |
| sharp_v_o | output | 1 | Vertical 2-tap sharpen enable |

## Verification
The assertions assume that the table read port answers within the same cycle. They also assume that frame_i and start_i are single-cycle levels sampled at the clock edge, so a strobe held high through a load is simply seen again once the loader is idle. The bench drives every input one time unit after a rising edge and builds the table from a fixed function of the address, so the table is always defined. It gives frame strobes and extra starts inside loads, so that the deferred swap and the ignored start are exercised under the same assumptions.

// File: rtl/scl_coef_pkg.sv
package scl_coef_pkg;
  localparam int NUM_FILT_TYPES = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_SWAP  = 2'd2
  } ld_state_e;

  // code bit 0 selects the horizontal direction
  function automatic logic type_is_horz(input logic [2:0] code);
    return code[0];
  endfunction
endpackage

// File: rtl/coef_addr_gen.sv
module coef_addr_gen #(
  parameter int PH_W    = 6,
  parameter int PAIR_W  = 2,
  parameter int LAST_PH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [PAIR_W-1:0] last_pair_i,
  output logic [PH_W-1:0]   ph_o,
  output logic [PAIR_W-1:0] pair_o,
  output logic              last_o
);
  logic [PH_W-1:0]   ph_q;
  logic [PAIR_W-1:0] pair_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      pair_q <= '0;
    end else if (clr_i) begin
      ph_q   <= '0;
      pair_q <= '0;
    end else if (step_i) begin
      if (pair_q == last_pair_i) begin
        pair_q <= '0;
        ph_q   <= ph_q + 1'b1;
      end else begin
        pair_q <= pair_q + 1'b1;
      end
    end
  end

  assign ph_o   = ph_q;
  assign pair_o = pair_q;
  assign last_o = (ph_q == PH_W'(LAST_PH)) && (pair_q == last_pair_i);
endmodule

// File: rtl/coef_pack.sv
module coef_pack #(
  parameter int TBL_W   = 12,
  parameter int TAP_W   = 4,
  parameter int PH_W    = 6,
  parameter int PAIR_W  = 2,
  parameter int TADDR_W = 9,
  localparam int COEF_W = TBL_W + 2
) (
  input  logic [TAP_W-1:0]   taps_i,
  input  logic [PH_W-1:0]    ph_i,
  input  logic [PAIR_W-1:0]  pair_i,
  input  logic [TBL_W-1:0]   even_raw_i,
  input  logic [TBL_W-1:0]   odd_raw_i,
  output logic [TADDR_W-1:0] even_addr_o,
  output logic [TADDR_W-1:0] odd_addr_o,
  output logic [COEF_W-1:0]  even_o,
  output logic [COEF_W-1:0]  odd_o
);
  logic [TADDR_W-1:0] base;
  logic [TADDR_W-1:0] odd_idx;
  logic               odd_ok;

  always_comb begin
    base        = TADDR_W'(ph_i) * TADDR_W'(taps_i);
    even_addr_o = base + {TADDR_W'(pair_i), 1'b0} ;
    odd_addr_o  = even_addr_o + 1'b1;
    odd_idx     = {TADDR_W'(pair_i), 1'b1};
    odd_ok      = odd_idx < TADDR_W'(taps_i);
    even_o      = {even_raw_i, 2'b00};
    odd_o       = odd_ok ? {odd_raw_i, 2'b00} : '0;
  end
endmodule

// File: rtl/coef_table_hist.sv
module coef_table_hist #(
  parameter int NUM_TYPES = 6,
  parameter int ID_W      = 8,
  parameter int TYPE_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TYPE_W-1:0] qry_type_i,
  input  logic [ID_W-1:0]   qry_id_i,
  output logic              changed_o,
  input  logic              upd_i,
  input  logic [TYPE_W-1:0] upd_type_i,
  input  logic [ID_W-1:0]   upd_id_i
);
  logic [NUM_TYPES-1:0] hit;
  logic [NUM_TYPES-1:0] sel;

  for (genvar g = 0; g < NUM_TYPES; g++) begin : g_slot
    logic            vld_q;
    logic [ID_W-1:0] id_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        id_q  <= '0;
      end else if (upd_i && upd_type_i == TYPE_W'(g)) begin
        vld_q <= 1'b1;
        id_q  <= upd_id_i;
      end
    end

    assign sel[g] = (qry_type_i == TYPE_W'(g));
    assign hit[g] = vld_q && (id_q == qry_id_i);
  end

  assign changed_o = ~|(sel & hit);
endmodule

// File: rtl/coef_bank_ctl.sv
module coef_bank_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_pend_i,
  input  logic idle_i,
  input  logic frame_i,
  output logic active_o
);
  logic active_q, pend_q, flip;

  // swap deferred until a frame edge finds the loader idle
  assign flip = frame_i && idle_i && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      active_q <= active_q ^ flip;
      pend_q   <= set_pend_i | (pend_q & ~flip);
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/scl_coef_loader.sv
module scl_coef_loader
  import scl_coef_pkg::*;
#(
  parameter int TBL_W      = 12,
  parameter int ID_W       = 8,
  parameter int MAX_TAPS   = 8,
  parameter int NUM_PHASES = 64,
  parameter int SHARP_W    = 3,
  localparam int COEF_W    = TBL_W + 2,
  localparam int LOAD_PH   = NUM_PHASES / 2 + 1,
  localparam int PH_W      = $clog2(LOAD_PH + 1),
  localparam int PAIR_W    = $clog2((MAX_TAPS + 1) / 2),
  localparam int TAP_W     = $clog2(MAX_TAPS + 1),
  localparam int TADDR_W   = $clog2(LOAD_PH * MAX_TAPS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [2:0]         filt_type_i,
  input  logic [TAP_W-1:0]   taps_i,
  input  logic [TAP_W-1:0]   partner_taps_i,
  input  logic [SHARP_W-1:0] sharp_lvl_i,
  input  logic [ID_W-1:0]    tbl_id_i,
  input  logic               frame_i,
  output logic [TADDR_W-1:0] tbl_even_addr_o,
  output logic [TADDR_W-1:0] tbl_odd_addr_o,
  input  logic [TBL_W-1:0]   tbl_even_i,
  input  logic [TBL_W-1:0]   tbl_odd_i,
  output logic               ram_we_o,
  output logic               ram_bank_o,
  output logic [2:0]         ram_type_o,
  output logic [PH_W-1:0]    ram_phase_o,
  output logic [PAIR_W-1:0]  ram_pair_o,
  output logic [COEF_W-1:0]  ram_even_o,
  output logic               ram_even_en_o,
  output logic [COEF_W-1:0]  ram_odd_o,
  output logic               ram_odd_en_o,
  output logic               done_o,
  output logic               busy_o,
  output logic               active_bank_o,
  output logic               hc_h_o,
  output logic               hc_v_o,
  output logic               sharp_h_o,
  output logic               sharp_v_o
);
  ld_state_e         state_q, state_d;
  logic [2:0]        type_q;
  logic [TAP_W-1:0]  taps_q;
  logic [ID_W-1:0]   id_q;
  logic [PAIR_W-1:0] last_pair_q;
  logic              skip_done_q;
  logic [1:0]        hc_q, sharp_q;

  logic              cmd_ok, accept, hc_req, changed, skip, last_wr;
  logic [TAP_W-1:0]  taps_m1;
  logic              active;

  assign cmd_ok  = (filt_type_i < 3'(NUM_FILT_TYPES)) && (taps_i <= TAP_W'(MAX_TAPS));
  assign accept  = start_i && (state_q == ST_IDLE) && cmd_ok;
  assign hc_req  = (taps_i == TAP_W'(2)) && (partner_taps_i == TAP_W'(2));
  assign skip    = hc_req || (taps_i < TAP_W'(2)) || !changed;
  assign taps_m1 = taps_i - 1'b1;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept && !skip) state_d = ST_WRITE;
      ST_WRITE: if (last_wr) state_d = ST_SWAP;
      ST_SWAP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      type_q      <= '0;
      taps_q      <= '0;
      id_q        <= '0;
      last_pair_q <= '0;
      skip_done_q <= 1'b0;
      hc_q        <= '0;
      sharp_q     <= '0;
    end else begin
      state_q     <= state_d;
      skip_done_q <= accept && skip;
      if (accept) begin
        hc_q[type_is_horz(filt_type_i)]    <= hc_req;
        sharp_q[type_is_horz(filt_type_i)] <= hc_req && (sharp_lvl_i != '0);
        if (!skip) begin
          type_q      <= filt_type_i;
          taps_q      <= taps_i;
          id_q        <= tbl_id_i;
          last_pair_q <= taps_m1[PAIR_W:1];
        end
      end
    end
  end

  coef_table_hist #(
    .NUM_TYPES(NUM_FILT_TYPES), .ID_W(ID_W), .TYPE_W(3)
  ) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .qry_type_i (filt_type_i),
    .qry_id_i   (tbl_id_i),
    .changed_o  (changed),
    .upd_i      (state_q == ST_SWAP),
    .upd_type_i (type_q),
    .upd_id_i   (id_q)
  );

  coef_addr_gen #(
    .PH_W(PH_W), .PAIR_W(PAIR_W), .LAST_PH(LOAD_PH - 1)
  ) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (accept),
    .step_i      (state_q == ST_WRITE),
    .last_pair_i (last_pair_q),
    .ph_o        (ram_phase_o),
    .pair_o      (ram_pair_o),
    .last_o      (last_wr)
  );

  coef_pack #(
    .TBL_W(TBL_W), .TAP_W(TAP_W), .PH_W(PH_W), .PAIR_W(PAIR_W), .TADDR_W(TADDR_W)
  ) u_pack (
    .taps_i      (taps_q),
    .ph_i        (ram_phase_o),
    .pair_i      (ram_pair_o),
    .even_raw_i  (tbl_even_i),
    .odd_raw_i   (tbl_odd_i),
    .even_addr_o (tbl_even_addr_o),
    .odd_addr_o  (tbl_odd_addr_o),
    .even_o      (ram_even_o),
    .odd_o       (ram_odd_o)
  );

  coef_bank_ctl u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_pend_i (state_q == ST_SWAP),
    .idle_i     (state_q == ST_IDLE),
    .frame_i    (frame_i),
    .active_o   (active)
  );

  assign ram_we_o      = (state_q == ST_WRITE);
  assign ram_even_en_o = ram_we_o;
  assign ram_odd_en_o  = ram_we_o;
  assign ram_bank_o    = ~active;
  assign ram_type_o    = type_q;
  assign active_bank_o = active;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = skip_done_q || (state_q == ST_SWAP);
  assign hc_v_o        = hc_q[0];
  assign hc_h_o        = hc_q[1];
  assign sharp_v_o     = sharp_q[0];
  assign sharp_h_o     = sharp_q[1];
endmodule

// File: rtl/scl_coef_loader_chk.sv
module scl_coef_loader_chk #(
  parameter int COEF_W = 14,
  parameter int PH_W   = 6,
  parameter int PAIR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ram_we_o,
  input logic              ram_bank_o,
  input logic              active_bank_o,
  input logic              busy_o,
  input logic [PH_W-1:0]   ram_phase_o,
  input logic [PAIR_W-1:0] ram_pair_o,
  input logic [COEF_W-1:0] ram_even_o,
  input logic [COEF_W-1:0] ram_odd_o
);
  AST_WE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> busy_o); // R2

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_phase_o <= PH_W'(32))); // R2

  AST_FIRST_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_o) |-> (ram_phase_o == '0 && ram_pair_o == '0)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && $past(ram_we_o)) |->
      ((ram_phase_o == $past(ram_phase_o) && ram_pair_o == $past(ram_pair_o) + 1'b1) ||
       (ram_phase_o == $past(ram_phase_o) + 1'b1 && ram_pair_o == '0))); // R2

  AST_LOW_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_even_o[1:0] == 2'b00 && ram_odd_o[1:0] == 2'b00)); // R3

  AST_SHADOW_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_bank_o != active_bank_o)); // R4

  AST_NO_SWAP_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (active_bank_o == $past(active_bank_o))); // R5
endmodule

bind scl_coef_loader scl_coef_loader_chk #(
  .COEF_W(COEF_W), .PH_W(PH_W), .PAIR_W(PAIR_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ram_we_o      (ram_we_o),
  .ram_bank_o    (ram_bank_o),
  .active_bank_o (active_bank_o),
  .busy_o        (busy_o),
  .ram_phase_o   (ram_phase_o),
  .ram_pair_o    (ram_pair_o),
  .ram_even_o    (ram_even_o),
  .ram_odd_o     (ram_odd_o)
);

// File: tb/scl_coef_loader_bench.sv
`timescale 1ns/1ps
module scl_coef_loader_bench;
  localparam int TBL_W = 12, ID_W = 8, SHARP_W = 3;
  localparam int COEF_W = TBL_W + 2, PH_W = 6, PAIR_W = 2, TAP_W = 4, TADDR_W = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, frame = 1'b0;
  logic [2:0] ftype = '0;
  logic [TAP_W-1:0] taps = '0, ptaps = '0;
  logic [SHARP_W-1:0] sharp = '0;
  logic [ID_W-1:0] tid = '0;
  logic [TADDR_W-1:0] ea, oa;
  logic [TBL_W-1:0] ed, od;
  logic we, bank, een, oen, done, busy, act, hch, hcv, shh, shv;
  logic [2:0] rtype;
  logic [PH_W-1:0] rph;
  logic [PAIR_W-1:0] rpr;
  logic [COEF_W-1:0] reven, rodd;

  int n_chk = 0, n_bad = 0, n_we = 0, n_done = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  function automatic logic [TBL_W-1:0] tfun(input int a);
    return TBL_W'((a * 53 + 11) ^ (a << 4));
  endfunction

  assign ed = tfun(int'(ea));
  assign od = tfun(int'(oa));

  scl_coef_loader u_scl_coef_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .filt_type_i(ftype),
    .taps_i(taps), .partner_taps_i(ptaps), .sharp_lvl_i(sharp), .tbl_id_i(tid),
    .frame_i(frame), .tbl_even_addr_o(ea), .tbl_odd_addr_o(oa),
    .tbl_even_i(ed), .tbl_odd_i(od), .ram_we_o(we), .ram_bank_o(bank),
    .ram_type_o(rtype), .ram_phase_o(rph), .ram_pair_o(rpr),
    .ram_even_o(reven), .ram_even_en_o(een), .ram_odd_o(rodd), .ram_odd_en_o(oen),
    .done_o(done), .busy_o(busy), .active_bank_o(act),
    .hc_h_o(hch), .hc_v_o(hcv), .sharp_h_o(shh), .sharp_v_o(shv)
  );

  // behavioural reference: mode 0 idle, 1 writing, 2 completing
  int m_mode, m_type, m_taps, m_id, m_ph, m_pr;
  bit m_pend, m_act, m_sdone;
  bit m_hc[2], m_sh[2];
  bit h_vld[6];
  int h_id[6];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_type = 0; m_taps = 0; m_id = 0; m_ph = 0; m_pr = 0;
      m_pend = 0; m_act = 0; m_sdone = 0;
      for (int i = 0; i < 2; i++) begin m_hc[i] = 0; m_sh[i] = 0; end
      for (int i = 0; i < 6; i++) begin h_vld[i] = 0; h_id[i] = 0; end
    end else begin
      bit flip, nsd, hcq, chg;
      flip = (m_mode == 0) && frame && m_pend;
      nsd = 0;
      case (m_mode)
        0: if (start && ftype < 6 && taps <= 8) begin
             hcq = (taps == 2) && (ptaps == 2);
             m_hc[ftype % 2] = hcq;
             m_sh[ftype % 2] = hcq && (sharp != 0);
             chg = !h_vld[ftype] || (h_id[ftype] != int'(tid));
             if (hcq || taps < 2 || !chg) nsd = 1;
             else begin
               m_mode = 1; m_type = int'(ftype); m_taps = int'(taps); m_id = int'(tid);
               m_ph = 0; m_pr = 0;
             end
           end
        1: if (m_pr == (m_taps + 1) / 2 - 1) begin
             m_pr = 0;
             if (m_ph == 32) m_mode = 2;
             m_ph++;
           end else m_pr++;
        default: begin
          m_pend = 1; h_vld[m_type] = 1; h_id[m_type] = m_id; m_mode = 0;
        end
      endcase
      if (flip) begin m_act = !m_act; m_pend = 0; end
      m_sdone = nsd;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint a, input longint e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, a, e, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !finished) begin
    bit ew;
    longint xe, xo;
    ew = (m_mode == 1);
    if (we) n_we++;
    if (done) n_done++;
    chk(we == ew, "R2 write strobe", we, ew);
    chk(busy == (m_mode != 0), "R2 busy", busy, m_mode != 0);
    chk(done == (m_sdone || m_mode == 2), "R5 done", done, m_sdone || m_mode == 2);
    chk(act == m_act, "R5 active bank", act, m_act);
    chk(hch == m_hc[1] && hcv == m_hc[0], "R8 hard-code flags", {hch, hcv}, {m_hc[1], m_hc[0]});
    chk(shh == m_sh[1] && shv == m_sh[0], "R8 sharpen flags", {shh, shv}, {m_sh[1], m_sh[0]});
    if (ew) begin
      xe = longint'({tfun(m_ph * m_taps + 2 * m_pr), 2'b00});
      xo = (2 * m_pr + 1 < m_taps) ? longint'({tfun(m_ph * m_taps + 2 * m_pr + 1), 2'b00}) : 0;
      chk(rph == m_ph, "R2 phase", rph, m_ph);
      chk(rpr == m_pr, "R2 pair", rpr, m_pr);
      chk(rtype == m_type, "R2 type", rtype, m_type);
      chk(reven == xe, "R3 even coef", reven, xe);
      chk(rodd == xo, "R3 odd coef", rodd, xo);
      chk(een && oen, "R3 half enables", {een, oen}, 3);
      chk(bank == !m_act, "R4 shadow bank", bank, !m_act);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic go(input int t, input int tp, input int pt, input int sh, input int id);
    @(posedge clk); #1;
    start = 1; ftype = 3'(t); taps = TAP_W'(tp); ptaps = TAP_W'(pt);
    sharp = SHARP_W'(sh); tid = ID_W'(id);
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    cyc(2);
  endtask

  task automatic pulse_frame();
    @(posedge clk); #1; frame = 1;
    @(posedge clk); #1; frame = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    int w0, d0;
    bit a0;
    cyc(3);
    @(negedge clk);
    chk(!we && !done && !busy && !act && !hch && !hcv && !shh && !shv,
        "R1 reset state", {we, done, busy, act}, 0);
    rst_n = 1;
    cyc(2);

    // R2 R3: luma horizontal, 4 taps
    w0 = n_we; d0 = n_done;
    go(1, 4, 4, 0, 5); wait_idle();
    chk(n_we - w0 == 66, "R2 write count 4 taps", n_we - w0, 66);
    chk(n_done - d0 == 1, "R5 one done pulse", n_done - d0, 1);
    chk(act == 0, "R5 no swap before frame", act, 0);
    pulse_frame(); cyc(1);
    chk(act == 1, "R5 swap at frame", act, 1);

    // odd taps, with ignored start and deferred frame
    w0 = n_we;
    go(0, 3, 3, 0, 7);
    cyc(5);
    d0 = n_done;
    go(4, 8, 8, 0, 40);           // R9 start while busy
    wait_idle();
    chk(n_we - w0 == 66, "R9 busy start ignored, 3 taps writes", n_we - w0, 66);
    w0 = n_we;
    go(3, 5, 5, 0, 1);
    cyc(4);
    pulse_frame();                // pending swap from previous load, deferred
    cyc(1);
    chk(act == 1, "R5 swap deferred while busy", act, 1);
    wait_idle();
    chk(n_we - w0 == 99, "R2 write count 5 taps", n_we - w0, 99);
    pulse_frame(); cyc(1);
    chk(act == 0, "R5 single swap after load", act, 0);

    // R6 unchanged table
    w0 = n_we; d0 = n_done;
    go(1, 4, 4, 0, 5); cyc(3);
    chk(n_we == w0, "R6 no writes for same table", n_we - w0, 0);
    chk(n_done - d0 == 1, "R6 done pulse", n_done - d0, 1);
    pulse_frame(); cyc(1);
    chk(act == 0, "R6 no swap pending", act, 0);

    // R7 one tap
    w0 = n_we; d0 = n_done;
    go(2, 1, 4, 0, 3); cyc(3);
    chk(n_we == w0, "R7 no writes for 1 tap", n_we - w0, 0);
    chk(n_done - d0 == 1, "R7 done pulse", n_done - d0, 1);

    // R8 hard-coded 2-tap
    w0 = n_we;
    go(3, 2, 2, 3, 50); cyc(2);
    chk(hch == 1 && shh == 1, "R8 horiz hard-code with sharpen", {hch, shh}, 3);
    go(2, 2, 2, 0, 51); cyc(2);
    chk(hcv == 1 && shv == 0, "R8 vert hard-code no sharpen", {hcv, shv}, 2);
    chk(n_we == w0, "R8 no writes when hard-coded", n_we - w0, 0);
    go(5, 2, 4, 5, 2); wait_idle();
    chk(hch == 0 && shh == 0, "R8 horiz flags cleared", {hch, shh}, 0);
    chk(n_we - w0 == 33, "R8 2-tap RAM load", n_we - w0, 33);

    // R9 invalid commands
    w0 = n_we; d0 = n_done;
    go(6, 4, 4, 0, 9); cyc(2);
    go(0, 9, 4, 0, 9); cyc(2);
    chk(n_we == w0 && n_done == d0, "R9 invalid starts ignored", n_done - d0, 0);

    // R10 frame without pending swap
    pulse_frame(); cyc(1);
    a0 = act;
    pulse_frame(); cyc(1);
    chk(act == a0, "R10 frame with nothing pending", act, a0);

    // wide filters
    w0 = n_we;
    go(4, 8, 8, 0, 4); wait_idle();
    go(5, 7, 7, 0, 9); wait_idle();
    chk(n_we - w0 == 264, "R2 write count 8 and 7 taps", n_we - w0, 264);
    pulse_frame(); cyc(1);
    chk(act == !a0, "R5 swap after wide loads", act, !a0);
    cyc(3);
    summary();
  end
endmodule